// File: doc/BRIEF.md
# Bit-Serial Constant-Weight Neuron Dot Product

This block produces the weighted sum of one neuron's inputs. Every synapse carries a 4-bit signed weight that is fixed when the design is elaborated. The weights are never read from storage. Activations are 8-bit unsigned numbers. They arrive one bit-plane per accepted cycle, least significant plane first. A plane is a vector that holds the same bit of every input.

There are no per-input multipliers. The inputs are wired into sixteen bins, one for each weight value. On every plane, the block counts the set bits in each bin. It multiplies each count by the bin's constant, adds the products, and shifts the plane sum by the plane's significance. It then adds the result into a signed accumulator.

A producer marks the first plane of an operand and the last plane of that operand. One cycle after the last plane is accepted, the finished dot product appears together with a one-cycle valid pulse.

Top module: `bitserial_popcount_neuron`

## Requirements
- R1: The weight of input i is the nibble at bits [4i+3:4i] of WEIGHT_MAP, read as two's complement (range -8 to +7; code 4'b1000 is -8 and code 4'b0111 is +7).
- R2: The contribution of an accepted plane is the sum of w_i over all inputs whose plane bit is 1. Inputs whose weight is 0 add nothing.
- R3: The per-bin set-bit count never exceeds the number of inputs wired to that bin.
- R4: The k-th accepted plane of an operand, counted from 0 at the plane marked first, is weighted by 2^k. Planes arrive least significant first.
- R5: A plane accepted with plane_first set discards whatever the accumulator held before, including an operand that was abandoned without a last plane.
- R6: One cycle after a plane is accepted with plane_last set, result_vld is 1 for exactly that cycle. In the same cycle, result holds the signed dot product of the operand.
- R7: In cycles with plane_vld low, plane_bits, plane_first and plane_last have no effect on the result.
- R8: Between valid pulses, result keeps its last value.
- R9: An operand may end early. If last arrives after m < 8 planes, the result is the dot product of the activations' low m bits. A plane marked both first and last is a one-plane operand.
- R10: While rst is high and after it falls, result is 0 and result_vld is 0 until the first accepted last plane.
- R11: The result width holds every sum from all-ones activations without overflow. With the default map, 255 on every input gives -8160.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| plane_vld | input | 1 | A plane is present this cycle |
| plane_first | input | 1 | Present plane is bit 0 of a new operand |
| plane_last | input | 1 | Present plane ends the operand |
| plane_bits | input | N | One bit of every activation, input i on bit i |
| result | output | RES_W | Signed dot product, RES_W = ACT_BITS + 4 + clog2(N) |
| result_vld | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench builds the block with N = 64 and a map that repeats a permutation of all sixteen nibble codes four times. Every weight value from -8 to +7 is therefore present, including the zero bin and both extremes, and every bin has four members. This brings the bin-only stimuli within reach: weight-zero-only, positive-only and negative-only operands. It also reaches the all-ones full-scale sum of -8160 in an 18-bit result. Random activations with random idle gaps, early endings and abandoned operands use the same default width, so the plane-significance arithmetic is exercised at every shift from 0 to 7.

// File: rtl/bspn_pkg.sv
package bspn_pkg;

    localparam int WB         = 4;
    localparam int NUM_GROUPS = 1 << WB;

    typedef logic [WB-1:0] wcode_t;

    typedef struct packed {
        logic vld;
        logic first;
        logic last;
    } plane_ctl_t;

    // signed value of a weight code
    function automatic int code_value(input wcode_t c);
        return int'($signed(c));
    endfunction

endpackage

// File: rtl/group_popcount.sv
module group_popcount #(
    parameter int          N    = 64,
    parameter int          CW   = 7,
    parameter logic [N-1:0] MASK = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  plane,
    output logic [CW-1:0] count
);
    localparam int MEMBERS = $countones(MASK);

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            if (MASK[i]) count = count + CW'(plane[i]);
        end
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= MEMBERS);

endmodule

// File: rtl/weight_binner.sv
module weight_binner
    import bspn_pkg::*;
#(
    parameter int               N          = 64,
    parameter int               CW         = 7,
    parameter logic [WB*N-1:0]  WEIGHT_MAP = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  plane,
    output logic [CW-1:0] counts [NUM_GROUPS]
);
    function automatic logic [N-1:0] group_mask(input int g);
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) m[i] = (WEIGHT_MAP[WB*i +: WB] == WB'(g));
        return m;
    endfunction

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bin
        localparam logic [N-1:0] MASK = group_mask(g);
        group_popcount #(.N(N), .CW(CW), .MASK(MASK)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .plane (plane),
            .count (counts[g])
        );
    end

endmodule

// File: rtl/plane_combiner.sv
module plane_combiner
    import bspn_pkg::*;
#(
    parameter int CW   = 7,
    parameter int PS_W = 11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CW-1:0]          counts [NUM_GROUPS],
    output logic signed [PS_W-1:0] psum
);
    always_comb begin
        int s;
        s = 0;
        // bin 0 has weight zero and is skipped
        for (int g = 1; g < NUM_GROUPS; g++) begin
            s = s + int'(counts[g]) * code_value(wcode_t'(g));
        end
        psum = PS_W'(s);
    end

    logic all_zero;
    always_comb begin
        all_zero = 1'b1;
        for (int g = 1; g < NUM_GROUPS; g++) if (counts[g] != '0) all_zero = 1'b0;
    end

    p_zero_counts_r2: assert property (@(posedge clk) disable iff (rst)
        all_zero |-> psum == '0);

endmodule

// File: rtl/serial_accum.sv
module serial_accum
    import bspn_pkg::*;
#(
    parameter int ACT_BITS = 8,
    parameter int PS_W     = 11,
    parameter int RES_W    = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  plane_ctl_t              ctl,
    input  logic signed [PS_W-1:0]  psum,
    output logic signed [RES_W-1:0] result,
    output logic                    result_vld
);
    localparam int IW = $clog2(ACT_BITS) + 1;

    logic [IW-1:0]            idx_q;
    logic signed [RES_W-1:0]  acc_q;
    logic [IW-1:0]            shift;
    logic signed [RES_W-1:0]  acc_next;

    always_comb begin
        logic signed [RES_W-1:0] term;
        shift    = ctl.first ? '0 : idx_q;
        term     = RES_W'(psum);
        acc_next = (ctl.first ? '0 : acc_q) + (term <<< shift);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            acc_q      <= '0;
            result     <= '0;
            result_vld <= 1'b0;
        end else begin
            result_vld <= ctl.vld && ctl.last;
            if (ctl.vld) begin
                idx_q <= shift + IW'(1);
                acc_q <= acc_next;
                if (ctl.last) result <= acc_next;
            end
        end
    end

    p_vld_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.vld && ctl.last) |=> result_vld);
    p_no_spurious_vld_r6: assert property (@(posedge clk) disable iff (rst)
        !(ctl.vld && ctl.last) |=> !result_vld);
    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !result_vld |-> $stable(result));
    p_first_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.vld && ctl.first && ctl.last && psum == '0) |=> result == '0);

endmodule

// File: rtl/bitserial_popcount_neuron.sv
module bitserial_popcount_neuron
    import bspn_pkg::*;
#(
    parameter int              N          = 64,
    parameter int              ACT_BITS   = 8,
    parameter logic [WB*N-1:0] WEIGHT_MAP = {(N/16){64'h3A7F_0C95_E1B8_246D}},
    localparam int             RES_W      = ACT_BITS + WB + $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    plane_vld,
    input  logic                    plane_first,
    input  logic                    plane_last,
    input  logic [N-1:0]            plane_bits,
    output logic signed [RES_W-1:0] result,
    output logic                    result_vld
);
    localparam int CW   = $clog2(N + 1);
    localparam int PS_W = WB + CW;

    logic [CW-1:0]          counts [NUM_GROUPS];
    logic signed [PS_W-1:0] psum;
    plane_ctl_t             ctl;

    assign ctl = '{vld: plane_vld, first: plane_first, last: plane_last};

    weight_binner #(.N(N), .CW(CW), .WEIGHT_MAP(WEIGHT_MAP)) u_bin (
        .clk    (clk),
        .rst    (rst),
        .plane  (plane_bits),
        .counts (counts)
    );

    plane_combiner #(.CW(CW), .PS_W(PS_W)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .counts (counts),
        .psum   (psum)
    );

    serial_accum #(.ACT_BITS(ACT_BITS), .PS_W(PS_W), .RES_W(RES_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .psum       (psum),
        .result     (result),
        .result_vld (result_vld)
    );

    p_reset_idle_r10: assert property (@(posedge clk)
        $past(rst) |-> !result_vld);

endmodule

// File: tb/bitserial_popcount_neuron_test.sv
module bitserial_popcount_neuron_test;
    localparam int N     = 64;
    localparam int RES_W = 8 + 4 + 6;
    localparam logic [4*N-1:0] MAP = {4{64'h3A7F_0C95_E1B8_246D}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic plane_vld = 1'b0, plane_first = 1'b0, plane_last = 1'b0;
    logic [N-1:0] plane_bits = '0;
    logic signed [RES_W-1:0] result;
    logic result_vld;

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0] acts [N];

    always #2 clk = ~clk;

    bitserial_popcount_neuron #(.N(N), .ACT_BITS(8), .WEIGHT_MAP(MAP)) uut (
        .clk(clk), .rst(rst), .plane_vld(plane_vld), .plane_first(plane_first),
        .plane_last(plane_last), .plane_bits(plane_bits),
        .result(result), .result_vld(result_vld)
    );

    function automatic int wt(input int i);
        return int'($signed(MAP[4*i +: 4]));
    endfunction

    function automatic longint expect_dot(input int np);
        longint s = 0;
        for (int i = 0; i < N; i++) s += longint'(wt(i)) * longint'(int'(acts[i]) & ((1 << np) - 1));
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "R6 watchdog", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic run_op(input int np, input int gap_max, input string req);
        longint exp = expect_dot(np);
        longint held;
        for (int k = 0; k < np; k++) begin
            @(negedge clk);
            plane_vld = 1'b1; plane_first = (k == 0); plane_last = (k == np - 1);
            for (int i = 0; i < N; i++) plane_bits[i] = acts[i][k];
            if (k != np - 1 && gap_max > 0) begin
                int gp = $urandom_range(gap_max, 0);
                for (int j = 0; j < gp; j++) begin
                    @(negedge clk);
                    plane_vld = 1'b0;
                    plane_bits = {$urandom, $urandom};
                    plane_first = 1'($urandom); plane_last = 1'($urandom);
                end
            end
        end
        @(negedge clk);
        plane_vld = 1'b0; plane_first = 1'b0; plane_last = 1'b0;
        check(result_vld == 1'b1, {req, " R6 vld"}, longint'(result_vld), 1);
        check(longint'(result) == exp, req, longint'(result), exp);
        held = longint'(result);
        @(negedge clk);
        check(result_vld == 1'b0, "R6 pulse width", longint'(result_vld), 0);
        check(longint'(result) == held, "R8 hold", longint'(result), held);
    endtask

    task automatic fill(input int mode);
        for (int i = 0; i < N; i++) begin
            case (mode)
                0: acts[i] = 8'd0;
                1: acts[i] = 8'hFF;
                2: acts[i] = (wt(i) > 0) ? 8'hFF : 8'd0;
                3: acts[i] = (wt(i) < 0) ? 8'hFF : 8'd0;
                4: acts[i] = (wt(i) == 0) ? 8'hFF : 8'd0;
                5: acts[i] = (i == 0) ? 8'd1 << ($urandom_range(7, 0)) : 8'd0;
                default: acts[i] = 8'($urandom);
            endcase
        end
    endtask

    initial begin
        void'($urandom(32'd20250101));
        repeat (3) @(negedge clk);
        check(result_vld == 1'b0, "R10 vld in reset", longint'(result_vld), 0);
        check(result == '0, "R10 result in reset", longint'(result), 0);
        rst = 1'b0;
        @(negedge clk);
        check(result_vld == 1'b0 && result == '0, "R10 after reset", longint'(result), 0);

        fill(0); run_op(8, 0, "R2 zeros");
        fill(1); run_op(8, 0, "R11 full scale");
        check(expect_dot(8) == -8160, "R11 model", expect_dot(8), -8160);
        fill(2); run_op(8, 0, "R1 positive weights");
        fill(3); run_op(8, 0, "R1 negative weights");
        fill(4); run_op(8, 0, "R2 zero bin");
        for (int t = 0; t < 8; t++) begin fill(5); run_op(8, 0, "R4 single bit significance"); end
        fill(6); run_op(3, 0, "R9 early last");
        fill(6); run_op(1, 0, "R9 first and last together");

        // abandoned operand then fresh one
        fill(6);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            plane_vld = 1'b1; plane_first = (k == 0); plane_last = 1'b0;
            plane_bits = {$urandom, $urandom};
        end
        run_op(8, 0, "R5 restart discards");

        for (int t = 0; t < 40; t++) begin
            fill(6);
            run_op(8, 3, "R7 random with gaps");
        end
        for (int t = 0; t < 10; t++) begin
            fill(6);
            run_op($urandom_range(8, 1), 2, "R9 random length");
        end

        summary();
        $finish;
    end

endmodule